// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher with Repeat Modes

This block sits beside a calendar timekeeper and checks, once per seconds tick, whether the current BCD time (month, date, hour, minute, second) agrees with a programmed alarm time. A five-bit repeat code chooses which time fields take part in the comparison. The choices are a yearly alarm on an exact date and time, or an alarm every month, day, hour, minute or second. A code that is not one of the six defined values is treated as the once-per-second setting, so a bad setting shows up at once.

A match sets a sticky alarm flag. If the alarm enable bit is set, the flag also pulls an active-low interrupt output low, as an open-drain pin would. Reading the flag register clears the flag and releases the interrupt. While the bus address pointer rests on the flag register address, the interrupt is held back. It is driven once the pointer moves to another address. The alarm enable bit is brought out so that the pin multiplexer can hand the shared output to the alarm function.

Top module: `rtc_alarm_matcher`

## Requirements
- R1: After reset, alarm_flag is 0, irq_n is 1 and alarm_en is 0. All five alarm registers are cleared, so a seconds tick at any time leaves the flag at 0.
- R2: Writes go to addresses BASE_ADDR+0..+4 and program month, date, hour, minute and second. The BCD value sits in bits 4:0 for month, 5:0 for date and hour, and 6:0 for minute and second. Bit 7 of the month register is the alarm enable, shown on alarm_en. The repeat code c[4:0] is stored as c4 at date bit 7, c3 at date bit 6, c2 at hour bit 7, c1 at minute bit 7 and c0 at second bit 7. A write to any other address changes nothing.
- R3: With code 00000, all five fields must equal the alarm values for the flag to set.
- R4: With code 10000, the month is ignored and the other four fields must match.
- R5: With code 11000, month and date are ignored, and hour, minute and second must match.
- R6: With code 11100, month, date and hour are ignored, and minute and second must match.
- R7: With code 11110, only the second is compared.
- R8: With code 11111, the flag sets on every tick. Any code other than the six listed here behaves the same way.
- R9: Comparison happens only in a cycle where sec_tick is 1. The flag is 1 in the cycle after such a matching tick and stays 1 until it is cleared.
- R10: A cycle with flag_rd at 1 (and no matching tick) clears alarm_flag in the next cycle. irq_n returns to 1 one cycle after that.
- R11: irq_n goes to 0 one cycle after alarm_flag rises when alarm_en is 1. With alarm_en at 0, irq_n stays 1 while the flag is set.
- R12: While bus_ptr equals FLAG_ADDR, irq_n stays 1 even with the flag and enable set. It goes to 0 one cycle after bus_ptr moves to a different address.
- R13: A date value of 0 with repeat code 00000 disables the alarm, because no calendar time has date 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse when the seconds count advances |
| cur_mon | input | 8 | Current month, BCD |
| cur_date | input | 8 | Current date, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_min | input | 8 | Current minute, BCD |
| cur_sec | input | 8 | Current second, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| flag_rd | input | 1 | Flag register read strobe; clears the flag |
| bus_ptr | input | ADDR_W | Current bus address pointer |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low alarm interrupt |
| alarm_en | output | 1 | Alarm enable bit; when 1 the shared pin serves the alarm |

## Verification
The bench uses the default parameters: an 8-bit address, the alarm window at 0x0A–0x0E and the flag register at 0x0F. With these values it can park the pointer exactly on the flag address and then move it away, and it can write to the neighbouring address 0x09 just outside the window to show that the write is ignored. For each repeat code, the bench applies one time that differs only in fields that code should ignore, and one time that differs in the first field it must compare. It also applies two undefined codes.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int NFIELD = 5;  // month, date, hour, minute, second
  localparam int F_MON  = 0;
  localparam int F_DATE = 1;
  localparam int F_HOUR = 2;
  localparam int F_MIN  = 3;
  localparam int F_SEC  = 4;

  typedef logic [7:0] bcd_t;
  typedef logic [4:0] rpt_code_t;

  // Bits of each register byte that carry the BCD value.
  function automatic bcd_t field_mask(input int idx);
    case (idx)
      F_MON:            field_mask = 8'h1F;
      F_DATE, F_HOUR:   field_mask = 8'h3F;
      default:          field_mask = 8'h7F;
    endcase
  endfunction

  // Repeat code to per-field ignore vector (bit i = field i ignored).
  // Undefined codes ignore every field: alarm each second.
  function automatic logic [NFIELD-1:0] ignore_of(input rpt_code_t code);
    case (code)
      5'b00000: ignore_of = 5'b00000;
      5'b10000: ignore_of = 5'b00001;
      5'b11000: ignore_of = 5'b00011;
      5'b11100: ignore_of = 5'b00111;
      5'b11110: ignore_of = 5'b01111;
      default:  ignore_of = 5'b11111;
    endcase
  endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [7:0]                   wr_data,
  output logic [NFIELD-1:0][7:0]       alarm_val,
  output rpt_code_t                    rpt_code,
  output logic                         afe
);

  logic [NFIELD-1:0][7:0] reg_q;
  logic [NFIELD-1:0]      sel;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign sel[i] = wr_en && (wr_addr == ADDR_W'(BASE_ADDR + i));

    always_ff @(posedge clk) begin
      if (rst)
        reg_q[i] <= '0;
      else if (sel[i])
        reg_q[i] <= wr_data;
    end

    assign alarm_val[i] = reg_q[i] & field_mask(i);
  end

  assign afe      = reg_q[F_MON][7];
  assign rpt_code = {reg_q[F_DATE][7], reg_q[F_DATE][6], reg_q[F_HOUR][7],
                     reg_q[F_MIN][7], reg_q[F_SEC][7]};

endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import rtc_alarm_pkg::*;
(
  input  logic [NFIELD-1:0][7:0] now_val,
  input  logic [NFIELD-1:0][7:0] alarm_val,
  input  rpt_code_t              rpt_code,
  output logic                   match
);

  logic [NFIELD-1:0] ignore;
  logic [NFIELD-1:0] hit;

  assign ignore = ignore_of(rpt_code);

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign hit[i] = ignore[i] ||
                    (((now_val[i] ^ alarm_val[i]) & field_mask(i)) == 8'h00);
  end

  assign match = &hit;

endmodule

// File: rtl/alarm_irq.sv
module alarm_irq (
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  input  logic match,
  input  logic flag_rd,
  input  logic afe,
  input  logic ptr_on_flag,
  output logic alarm_flag,
  output logic irq_n
);

  always_ff @(posedge clk) begin
    if (rst)
      alarm_flag <= 1'b0;
    else if (sec_tick && match)
      alarm_flag <= 1'b1;
    else if (flag_rd)
      alarm_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq_n <= 1'b1;
    else
      irq_n <= !(alarm_flag && afe && !ptr_on_flag);
  end

endmodule

// File: rtl/rtc_alarm_matcher.sv
module rtc_alarm_matcher
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 10,
  parameter int FLAG_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [7:0]        cur_mon,
  input  logic [7:0]        cur_date,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_sec,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              flag_rd,
  input  logic [ADDR_W-1:0] bus_ptr,
  output logic              alarm_flag,
  output logic              irq_n,
  output logic              alarm_en
);

  logic [NFIELD-1:0][7:0] now_val;
  logic [NFIELD-1:0][7:0] alarm_val;
  rpt_code_t              rpt_code;
  logic                   afe;
  logic                   match;
  logic                   ptr_on_flag;

  assign now_val[F_MON]  = cur_mon;
  assign now_val[F_DATE] = cur_date;
  assign now_val[F_HOUR] = cur_hour;
  assign now_val[F_MIN]  = cur_min;
  assign now_val[F_SEC]  = cur_sec;

  assign ptr_on_flag = (bus_ptr == ADDR_W'(FLAG_ADDR));
  assign alarm_en    = afe;

  alarm_regs #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .alarm_val (alarm_val),
    .rpt_code  (rpt_code),
    .afe       (afe)
  );

  alarm_compare u_cmp (
    .now_val   (now_val),
    .alarm_val (alarm_val),
    .rpt_code  (rpt_code),
    .match     (match)
  );

  alarm_irq u_irq (
    .clk         (clk),
    .rst         (rst),
    .sec_tick    (sec_tick),
    .match       (match),
    .flag_rd     (flag_rd),
    .afe         (afe),
    .ptr_on_flag (ptr_on_flag),
    .alarm_flag  (alarm_flag),
    .irq_n       (irq_n)
  );

endmodule

// File: rtl/rtc_alarm_matcher_chk.sv
module rtc_alarm_matcher_chk #(
  parameter int ADDR_W    = 8,
  parameter int FLAG_ADDR = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              sec_tick,
  input logic              flag_rd,
  input logic [ADDR_W-1:0] bus_ptr,
  input logic              alarm_flag,
  input logic              irq_n,
  input logic              alarm_en
);

  AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flag) |-> $past(sec_tick)); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && !flag_rd) |=> alarm_flag); // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && !sec_tick) |=> !alarm_flag); // R10

  AST_IRQ_NEEDS_AFE: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(alarm_en)); // R11

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(alarm_flag)); // R11

  AST_IRQ_DELIVERED: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && alarm_en && bus_ptr != ADDR_W'(FLAG_ADDR)) |=> !irq_n); // R11

  AST_PTR_WITHHOLDS: assert property (@(posedge clk) disable iff (rst)
    (bus_ptr == ADDR_W'(FLAG_ADDR)) |=> irq_n); // R12

endmodule

bind rtc_alarm_matcher rtc_alarm_matcher_chk #(
  .ADDR_W    (ADDR_W),
  .FLAG_ADDR (FLAG_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sec_tick   (sec_tick),
  .flag_rd    (flag_rd),
  .bus_ptr    (bus_ptr),
  .alarm_flag (alarm_flag),
  .irq_n      (irq_n),
  .alarm_en   (alarm_en)
);

// File: tb/test_rtc_alarm_matcher.sv
`timescale 1ns/1ps
module test_rtc_alarm_matcher;

  localparam int AW   = 8;
  localparam int BASE = 10;
  localparam int FLAG = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0;
  logic [7:0] cur_mon = 8'h01, cur_date = 8'h01, cur_hour = 8'h00,
              cur_min = 8'h00, cur_sec = 8'h00;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic flag_rd = 1'b0;
  logic [AW-1:0] bus_ptr = '0;
  logic alarm_flag, irq_n, alarm_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rtc_alarm_matcher #(.ADDR_W(AW), .BASE_ADDR(BASE), .FLAG_ADDR(FLAG)) i_rtc_alarm_matcher (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .cur_mon(cur_mon), .cur_date(cur_date), .cur_hour(cur_hour),
    .cur_min(cur_min), .cur_sec(cur_sec),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_rd(flag_rd), .bus_ptr(bus_ptr),
    .alarm_flag(alarm_flag), .irq_n(irq_n), .alarm_en(alarm_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Alarm time 12/25 10:30:45
  task automatic set_alarm(input logic afe, input logic [4:0] c);
    wr(AW'(BASE+0), {afe, 2'b00, 5'h12});
    wr(AW'(BASE+1), {c[4], c[3], 6'h25});
    wr(AW'(BASE+2), {c[2], 1'b0, 6'h10});
    wr(AW'(BASE+3), {c[1], 7'h30});
    wr(AW'(BASE+4), {c[0], 7'h45});
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_now(input logic [7:0] m, d, h, mi, s);
    cur_mon = m; cur_date = d; cur_hour = h; cur_min = mi; cur_sec = s;
  endtask

  // Tick once; returns with the flag visible.
  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic try_time(input string req, input logic [7:0] m, d, h, mi, s,
                          input logic exp);
    clear_flag();
    set_now(m, d, h, mi, s);
    tick();
    check(req, alarm_flag, exp);
  endtask

  task automatic t_reset();
    check("R1 flag", alarm_flag, 0);
    check("R1 irq_n", irq_n, 1);
    check("R1 alarm_en", alarm_en, 0);
    set_now(8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    tick();
    check("R1 cleared regs no alarm", alarm_flag, 0);
  endtask

  task automatic t_regmap();
    wr(AW'(BASE+0), 8'h80);
    check("R2 enable bit", alarm_en, 1);
    wr(AW'(BASE-1), 8'h00);
    check("R2 outside write ignored", alarm_en, 1);
    wr(AW'(FLAG), 8'h00);
    check("R2 flag addr write ignored", alarm_en, 1);
    wr(AW'(BASE+0), 8'h00);
    check("R2 enable cleared", alarm_en, 0);
  endtask

  task automatic t_codes();
    set_alarm(1'b0, 5'b00000);
    try_time("R3 exact match",     8'h12, 8'h25, 8'h10, 8'h30, 8'h45, 1);
    try_time("R3 month differs",   8'h11, 8'h25, 8'h10, 8'h30, 8'h45, 0);
    set_alarm(1'b0, 5'b10000);
    try_time("R4 month ignored",   8'h03, 8'h25, 8'h10, 8'h30, 8'h45, 1);
    try_time("R4 date differs",    8'h03, 8'h24, 8'h10, 8'h30, 8'h45, 0);
    set_alarm(1'b0, 5'b11000);
    try_time("R5 mon/date ignored",8'h03, 8'h07, 8'h10, 8'h30, 8'h45, 1);
    try_time("R5 hour differs",    8'h03, 8'h07, 8'h11, 8'h30, 8'h45, 0);
    set_alarm(1'b0, 5'b11100);
    try_time("R6 hour ignored",    8'h03, 8'h07, 8'h22, 8'h30, 8'h45, 1);
    try_time("R6 minute differs",  8'h03, 8'h07, 8'h22, 8'h31, 8'h45, 0);
    set_alarm(1'b0, 5'b11110);
    try_time("R7 minute ignored",  8'h03, 8'h07, 8'h22, 8'h59, 8'h45, 1);
    try_time("R7 second differs",  8'h03, 8'h07, 8'h22, 8'h59, 8'h44, 0);
    set_alarm(1'b0, 5'b11111);
    try_time("R8 every second",    8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 1);
    set_alarm(1'b0, 5'b01010);
    try_time("R8 invalid 01010",   8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 1);
    set_alarm(1'b0, 5'b00001);
    try_time("R8 invalid 00001",   8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 1);
  endtask

  task automatic t_tick_timing();
    set_alarm(1'b0, 5'b00000);
    clear_flag();
    set_now(8'h12, 8'h25, 8'h10, 8'h30, 8'h45);
    repeat (4) @(negedge clk);
    check("R9 no tick no flag", alarm_flag, 0);
    tick();
    check("R9 flag after tick", alarm_flag, 1);
    set_now(8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 flag held", alarm_flag, 1);
  endtask

  task automatic t_read_irq();
    set_alarm(1'b1, 5'b11111);
    clear_flag();
    bus_ptr = 8'h00;
    tick();
    check("R11 flag set", alarm_flag, 1);
    check("R11 irq not yet", irq_n, 1);
    @(negedge clk);
    check("R11 irq asserted", irq_n, 0);
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
    check("R10 flag cleared", alarm_flag, 0);
    @(negedge clk);
    check("R10 irq released", irq_n, 1);
    set_alarm(1'b0, 5'b11111);
    clear_flag();
    tick();
    repeat (2) @(negedge clk);
    check("R11 afe off flag", alarm_flag, 1);
    check("R11 afe off irq", irq_n, 1);
  endtask

  task automatic t_pointer();
    set_alarm(1'b1, 5'b11111);
    bus_ptr = AW'(FLAG);
    clear_flag();
    tick();
    repeat (3) @(negedge clk);
    check("R12 flag set", alarm_flag, 1);
    check("R12 irq withheld", irq_n, 1);
    bus_ptr = AW'(BASE);
    @(negedge clk);
    check("R12 irq delivered", irq_n, 0);
    clear_flag();
  endtask

  task automatic t_disable();
    wr(AW'(BASE+1), 8'h00);
    wr(AW'(BASE+2), 8'h10);
    wr(AW'(BASE+3), 8'h30);
    wr(AW'(BASE+4), 8'h45);
    try_time("R13 disabled", 8'h12, 8'h25, 8'h10, 8'h30, 8'h45, 0);
    try_time("R13 disabled other", 8'h12, 8'h01, 8'h10, 8'h30, 8'h45, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_codes();
    t_tick_timing();
    t_read_irq();
    t_pointer();
    t_disable();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule